// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block owns the 32-bit floating-point status and control word of a processor core. Each time the arithmetic datapath finishes a floating-point operation, it presents one cycle of condition flags: a vector of invalid-operation causes, overflow, underflow, divide-by-zero, inexact, fraction-rounded, fraction-inexact, a five-bit result-class field with write controls, and a record bit. In the following clock edge the block folds those flags into the status word. It sets each exception's own bit and the exception summary, and the enabled-exception summary when the matching enable is on. When the record bit is set it copies four summary bits into condition field 1. When any enabled exception fired during the operation, it raises a one-cycle program-interrupt request.

A whole-word load port lets the core place a new value in the register, for example to program the enable bits or the rounding mode. Within one operation the block gathers the enabled exceptions into a pending flag that exists only for that operation. The flag is turned into the interrupt request in the same cycle that the new status word becomes visible, so the request and the word that explains it appear together.

Bit layout (bit 31 is the most significant): 31 exception summary (FX), 30 enabled-exception summary (FEX), 29 invalid summary (VX), 28 overflow (OX), 27 underflow (UX), 26 divide-by-zero (ZX), 25 inexact (XX), 24..17 invalid-operation cause bits (cause input bit k lands on bit 17+k), 16 fraction rounded, 15 fraction inexact, 14..10 result-flags field (14 class bit, 13..10 condition code), 9 reserved, 8 invalid enable, 7 overflow enable, 6 underflow enable, 5 divide-by-zero enable, 4 inexact enable, 3..0 reserved or rounding control. Bits that no operation touches keep the value they were given by the load port.

Top module: `fp_status_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q`, `cr1_q` and `irq_q` become zero.
- R2: When `wr_en` is high, `status_q` takes `wr_data` one cycle later and `irq_q` is low. An operation presented in the same cycle is ignored entirely: it changes neither the status bits nor `cr1_q`.
- R3: For an operation, overflow, underflow and divide-by-zero each set their own bit (28, 27, 26) and FX (bit 31) when raised. When not raised they clear their own bit. FX is never cleared by an operation.
- R4: For an operation, inexact sets bit 25 and FX when raised. An operation never clears bit 25; only the load port can.
- R5: The invalid-operation causes are ORed into bits 24..17. If any cause is set, VX (bit 29) and FX are set. Bits already set stay set.
- R6: Each operation writes bit 16 from the fraction-rounded flag and bit 15 from the fraction-inexact flag, setting or clearing them.
- R7: If `op_rflags_we` is set, bits 14..10 are replaced by `op_rflags`. Otherwise, if `op_cc_we` is set, only bits 13..10 are replaced by `op_rflags[3:0]`. If neither is set, bits 14..10 are kept.
- R8: A raised exception whose enable is set (invalid with bit 8, overflow with 7, underflow with 6, divide-by-zero with 5, inexact with 4) sets FEX (bit 30). It also makes `irq_q` high for exactly the cycle in which the updated `status_q` first appears.
- R9: An operation with no enabled exception leaves FEX unchanged and gives `irq_q` low. `irq_q` is high only in the cycle after an accepted operation.
- R10: If `op_rc` is set for an accepted operation, `cr1_q` becomes {FX, FEX, VX, OX} of the updated word, in that order from bit 3 down to bit 0, in the same cycle. Otherwise `cr1_q` holds.
- R11: In a cycle with neither `wr_en` nor `op_valid`, the status word holds and `irq_q` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load whole status word |
| wr_data | input | 32 | Value to load |
| op_valid | input | 1 | An operation's flags are presented this cycle |
| op_inv_cause | input | 8 | Invalid-operation cause flags |
| op_ovf | input | 1 | Overflow raised |
| op_unf | input | 1 | Underflow raised |
| op_zdiv | input | 1 | Divide-by-zero raised |
| op_inex | input | 1 | Inexact raised |
| op_frac_rnd | input | 1 | Fraction was rounded |
| op_frac_inx | input | 1 | Fraction is inexact |
| op_rflags_we | input | 1 | Replace the whole result-flags field |
| op_cc_we | input | 1 | Replace only the condition-code subfield |
| op_rflags | input | 5 | New result-flags value |
| op_rc | input | 1 | Record summary into condition field 1 |
| status_q | output | 32 | Status and control word |
| cr1_q | output | 4 | Condition field 1 |
| irq_q | output | 1 | Floating-point enabled program-interrupt request |

## Verification
The bench goes after the asymmetry between the clearable exception bits and the sticky inexact bit. A design that cleared inexact on a quiet operation, or let overflow stay set, would differ from the model on the next cycle. It pairs raised exceptions with enables turned on and off, to catch a request that leaks from a disabled exception, that lasts two cycles, or that arrives a cycle away from the status word. It checks that a load beats a simultaneous operation, and that a condition-code-only write preserves the class bit. A wrong ordering of the four bits copied to condition field 1 also shows up as a mismatch.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int STAT_W   = 32;
  localparam int INV_N    = 8;
  localparam int RFL_W    = 5;
  localparam int CC_W     = 4;
  localparam int EXC_N    = 4;

  localparam int B_FX     = 31;
  localparam int B_FEX    = 30;
  localparam int B_VX     = 29;
  localparam int B_OX     = 28;
  localparam int B_INV_LO = 17;
  localparam int B_INV_HI = B_INV_LO + INV_N - 1;
  localparam int B_FR     = 16;
  localparam int B_FI     = 15;
  localparam int B_RFL_LO = 10;
  localparam int B_RFL_HI = B_RFL_LO + RFL_W - 1;
  localparam int B_VE     = 8;

  // per-exception status bit and enable bit: overflow, underflow, zero-divide, inexact
  localparam int EXC_POS [EXC_N] = '{28, 27, 26, 25};
  localparam int EN_POS  [EXC_N] = '{7, 6, 5, 4};
endpackage

// File: rtl/fpsu_exc_bit.sv
module fpsu_exc_bit #(
  parameter bit STICKY = 1'b0
) (
  input  logic raise,
  input  logic enable,
  input  logic cur_bit,
  output logic nxt_bit,
  output logic fire
);
  generate
    if (STICKY) begin : g_sticky
      assign nxt_bit = cur_bit | raise;
    end else begin : g_clear
      assign nxt_bit = raise;
    end
  endgenerate

  assign fire = raise & enable;
endmodule

// File: rtl/fpsu_inv_unit.sv
module fpsu_inv_unit #(
  parameter int N = 8
) (
  input  logic [N-1:0] cause,
  input  logic [N-1:0] cur_causes,
  input  logic         cur_vx,
  input  logic         enable,
  output logic [N-1:0] nxt_causes,
  output logic         nxt_vx,
  output logic         any,
  output logic         fire
);
  assign any        = |cause;
  assign nxt_causes = cur_causes | cause;
  assign nxt_vx     = cur_vx | any;
  assign fire       = any & enable;
endmodule

// File: rtl/fpsu_rflags_merge.sv
module fpsu_rflags_merge #(
  parameter int W  = 5,
  parameter int CW = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] new_val,
  input  logic         full_we,
  input  logic         cc_we,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (full_we) begin
      nxt = new_val;
    end else if (cc_we) begin
      nxt[CW-1:0] = new_val[CW-1:0];
    end
  end
endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
  import fpsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              op_valid,
  input  logic [INV_N-1:0]  op_inv_cause,
  input  logic              op_ovf,
  input  logic              op_unf,
  input  logic              op_zdiv,
  input  logic              op_inex,
  input  logic              op_frac_rnd,
  input  logic              op_frac_inx,
  input  logic              op_rflags_we,
  input  logic              op_cc_we,
  input  logic [RFL_W-1:0]  op_rflags,
  input  logic              op_rc,
  output logic [STAT_W-1:0] status_q,
  output logic [CC_W-1:0]   cr1_q,
  output logic              irq_q
);
  logic [EXC_N-1:0]  raise_v;
  logic [EXC_N-1:0]  exc_nxt;
  logic [EXC_N-1:0]  exc_fire;
  logic [INV_N-1:0]  inv_nxt;
  logic              vx_nxt;
  logic              inv_any;
  logic              inv_fire;
  logic [RFL_W-1:0]  rfl_nxt;
  logic              pending;
  logic [STAT_W-1:0] nxt;

  assign raise_v = {op_inex, op_zdiv, op_unf, op_ovf};

  genvar gi;
  generate
    for (gi = 0; gi < EXC_N; gi++) begin : g_exc
      fpsu_exc_bit #(.STICKY(gi == EXC_N - 1)) u_bit (
        .raise   (raise_v[gi]),
        .enable  (status_q[EN_POS[gi]]),
        .cur_bit (status_q[EXC_POS[gi]]),
        .nxt_bit (exc_nxt[gi]),
        .fire    (exc_fire[gi])
      );
    end
  endgenerate

  fpsu_inv_unit #(.N(INV_N)) u_inv (
    .cause      (op_inv_cause),
    .cur_causes (status_q[B_INV_HI:B_INV_LO]),
    .cur_vx     (status_q[B_VX]),
    .enable     (status_q[B_VE]),
    .nxt_causes (inv_nxt),
    .nxt_vx     (vx_nxt),
    .any        (inv_any),
    .fire       (inv_fire)
  );

  fpsu_rflags_merge #(.W(RFL_W), .CW(CC_W)) u_rfl (
    .cur     (status_q[B_RFL_HI:B_RFL_LO]),
    .new_val (op_rflags),
    .full_we (op_rflags_we),
    .cc_we   (op_cc_we),
    .nxt     (rfl_nxt)
  );

  // pending lives only for the operation being folded in this cycle
  assign pending = inv_fire | (|exc_fire);

  always_comb begin
    nxt = status_q;
    nxt[B_INV_HI:B_INV_LO] = inv_nxt;
    nxt[B_VX] = vx_nxt;
    for (int i = 0; i < EXC_N; i++) begin
      nxt[EXC_POS[i]] = exc_nxt[i];
    end
    nxt[B_FX]  = status_q[B_FX] | inv_any | (|raise_v);
    nxt[B_FEX] = status_q[B_FEX] | pending;
    nxt[B_FR]  = op_frac_rnd;
    nxt[B_FI]  = op_frac_inx;
    nxt[B_RFL_HI:B_RFL_LO] = rfl_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      cr1_q    <= '0;
      irq_q    <= 1'b0;
    end else if (wr_en) begin
      status_q <= wr_data;
      irq_q    <= 1'b0;
    end else if (op_valid) begin
      status_q <= nxt;
      irq_q    <= pending;
      if (op_rc) begin
        cr1_q <= {nxt[B_FX], nxt[B_FEX], nxt[B_VX], nxt[B_OX]};
      end
    end else begin
      irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_status_ctl_chk.sv
module fp_status_ctl_chk
  import fpsu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic              op_valid,
  input logic              op_ovf,
  input logic              op_rc,
  input logic [STAT_W-1:0] status_q,
  input logic [CC_W-1:0]   cr1_q,
  input logic              irq_q
);
  a_r8_irq_with_fex: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (status_q[B_FEX] && status_q[B_FX]));

  a_r9_irq_needs_op: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(op_valid) && !$past(wr_en)));

  a_r4_inexact_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status_q[25]) && !$past(wr_en)) |-> status_q[25]);

  a_r3_fx_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status_q[B_FX]) && !$past(wr_en)) |-> status_q[B_FX]);

  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid && op_ovf && !wr_en)) |-> (status_q[B_OX] && status_q[B_FX]));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (status_q == $past(wr_data) && !irq_q));

  a_r10_cr1_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid && op_rc && !wr_en)) |-> $stable(cr1_q));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid) && !$past(wr_en)) |-> ($stable(status_q) && !irq_q));
endmodule

bind fp_status_ctl fp_status_ctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .op_valid (op_valid),
  .op_ovf   (op_ovf),
  .op_rc    (op_rc),
  .status_q (status_q),
  .cr1_q    (cr1_q),
  .irq_q    (irq_q)
);

// File: tb/fp_status_ctl_test.sv
module fp_status_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_inv_cause = '0;
  logic        op_ovf = 1'b0, op_unf = 1'b0, op_zdiv = 1'b0, op_inex = 1'b0;
  logic        op_frac_rnd = 1'b0, op_frac_inx = 1'b0;
  logic        op_rflags_we = 1'b0, op_cc_we = 1'b0;
  logic [4:0]  op_rflags = '0;
  logic        op_rc = 1'b0;
  logic [31:0] status_q;
  logic [3:0]  cr1_q;
  logic        irq_q;

  integer n_chk = 0, n_fail = 0;
  bit [31:0] ms;
  bit [3:0]  mc;
  bit        mi;
  string     tag = "R1";

  always #2.5 clk = ~clk;

  fp_status_ctl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .op_valid(op_valid), .op_inv_cause(op_inv_cause),
    .op_ovf(op_ovf), .op_unf(op_unf), .op_zdiv(op_zdiv), .op_inex(op_inex),
    .op_frac_rnd(op_frac_rnd), .op_frac_inx(op_frac_inx),
    .op_rflags_we(op_rflags_we), .op_cc_we(op_cc_we), .op_rflags(op_rflags),
    .op_rc(op_rc), .status_q(status_q), .cr1_q(cr1_q), .irq_q(irq_q)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // behavioural reference: one accepted operation folded into ms
  task automatic model_step();
    bit fire;
    fire = 1'b0;
    if (rst) begin
      ms = 0; mc = 0; mi = 0;
    end else if (wr_en) begin
      ms = wr_data; mi = 0;
    end else if (op_valid) begin
      if (op_inv_cause != 0) begin
        ms = ms | (32'(op_inv_cause) << 17);
        ms[29] = 1; ms[31] = 1;
        if (ms[8]) begin ms[30] = 1; fire = 1; end
      end
      if (op_ovf) begin ms[28] = 1; ms[31] = 1; if (ms[7]) begin ms[30] = 1; fire = 1; end end
      else ms[28] = 0;
      if (op_unf) begin ms[27] = 1; ms[31] = 1; if (ms[6]) begin ms[30] = 1; fire = 1; end end
      else ms[27] = 0;
      if (op_zdiv) begin ms[26] = 1; ms[31] = 1; if (ms[5]) begin ms[30] = 1; fire = 1; end end
      else ms[26] = 0;
      if (op_inex) begin ms[25] = 1; ms[31] = 1; if (ms[4]) begin ms[30] = 1; fire = 1; end end
      ms[16] = op_frac_rnd;
      ms[15] = op_frac_inx;
      if (op_rflags_we) ms[14:10] = op_rflags;
      else if (op_cc_we) ms[13:10] = op_rflags[3:0];
      if (op_rc) mc = {ms[31], ms[30], ms[29], ms[28]};
      mi = fire;
    end else begin
      mi = 0;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #2;
    chk({tag, " status"}, status_q, ms);
    chk({tag, " cr1"}, 32'(cr1_q), 32'(mc));
    chk({tag, " irq"}, 32'(irq_q), 32'(mi));
  endtask

  task automatic clr_in();
    wr_en = 0; op_valid = 0; op_inv_cause = 0; op_ovf = 0; op_unf = 0;
    op_zdiv = 0; op_inex = 0; op_frac_rnd = 0; op_frac_inx = 0;
    op_rflags_we = 0; op_cc_we = 0; op_rflags = 0; op_rc = 0;
  endtask

  task automatic load(input logic [31:0] v);
    clr_in(); wr_en = 1; wr_data = v; tick(); clr_in();
  endtask

  task automatic op(input logic [7:0] inv, input logic o, input logic u,
                    input logic z, input logic x, input logic rc);
    clr_in(); op_valid = 1; op_inv_cause = inv; op_ovf = o; op_unf = u;
    op_zdiv = z; op_inex = x; op_rc = rc; tick(); clr_in();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tag = "R1";
    tick(); tick();
    chk("R1 status zero", status_q, 32'h0);
    rst = 0;

    tag = "R3";
    op(8'h00, 1, 0, 0, 0, 0);
    chk("R3 ox set", 32'(status_q[28]), 1);
    chk("R3 fx set", 32'(status_q[31]), 1);
    op(8'h00, 0, 1, 1, 0, 0);
    chk("R3 ox cleared", 32'(status_q[28]), 0);
    chk("R3 ux zx set", 32'(status_q[27:26]), 3);
    chk("R9 no irq disabled", 32'(irq_q), 0);
    op(8'h00, 0, 0, 0, 0, 0);
    chk("R3 fx kept", 32'(status_q[31]), 1);

    tag = "R4";
    op(8'h00, 0, 0, 0, 1, 0);
    op(8'h00, 0, 0, 0, 0, 0);
    chk("R4 inexact sticky", 32'(status_q[25]), 1);

    tag = "R5";
    op(8'h05, 0, 0, 0, 0, 0);
    op(8'h80, 0, 0, 0, 0, 0);
    chk("R5 causes ored", 32'(status_q[24:17]), 32'h85);
    chk("R5 vx set", 32'(status_q[29]), 1);

    tag = "R10";
    op(8'h00, 1, 0, 0, 0, 1);
    chk("R10 cr1 order", 32'(cr1_q), 32'b1011);
    op(8'h00, 0, 0, 0, 0, 0);
    chk("R10 cr1 hold", 32'(cr1_q), 32'b1011);

    tag = "R2";
    load(32'h0000_0180);
    chk("R2 loaded", status_q, 32'h0000_0180);
    clr_in(); wr_en = 1; wr_data = 32'h0000_0100; op_valid = 1; op_ovf = 1; op_rc = 1;
    tick(); clr_in();
    chk("R2 op ignored", status_q, 32'h0000_0100);
    chk("R2 cr1 untouched", 32'(cr1_q), 32'b1011);

    tag = "R8";
    load(32'h0000_0080);
    op(8'h00, 1, 0, 0, 0, 1);
    chk("R8 irq with status", 32'(irq_q), 1);
    chk("R8 fex", 32'(status_q[30]), 1);
    chk("R10 cr1 after enabled", 32'(cr1_q), 32'b1101);
    tick();
    chk("R8 irq one cycle", 32'(irq_q), 0);
    load(32'h0000_0010);
    op(8'h00, 1, 1, 1, 0, 0);
    chk("R9 irq off other enables", 32'(irq_q), 0);
    chk("R9 fex unchanged", 32'(status_q[30]), 0);
    op(8'h00, 0, 0, 0, 1, 0);
    chk("R8 inexact enabled irq", 32'(irq_q), 1);
    load(32'h0000_0100);
    op(8'h02, 0, 0, 0, 0, 0);
    chk("R8 invalid enabled irq", 32'(irq_q), 1);

    tag = "R6";
    clr_in(); op_valid = 1; op_frac_rnd = 1; tick(); clr_in();
    chk("R6 fr set fi clear", 32'(status_q[16:15]), 2);
    clr_in(); op_valid = 1; op_frac_inx = 1; tick(); clr_in();
    chk("R6 fr clear fi set", 32'(status_q[16:15]), 1);

    tag = "R7";
    clr_in(); op_valid = 1; op_rflags_we = 1; op_rflags = 5'h1A; tick(); clr_in();
    chk("R7 full replace", 32'(status_q[14:10]), 32'h1A);
    clr_in(); op_valid = 1; op_cc_we = 1; op_rflags = 5'h05; tick(); clr_in();
    chk("R7 cc only keeps class", 32'(status_q[14:10]), 32'h15);
    clr_in(); op_valid = 1; op_rflags = 5'h03; tick(); clr_in();
    chk("R7 no write holds", 32'(status_q[14:10]), 32'h15);
    clr_in(); op_valid = 1; op_rflags_we = 1; op_cc_we = 1; op_rflags = 5'h02; tick(); clr_in();
    chk("R7 full wins", 32'(status_q[14:10]), 32'h02);

    tag = "R11";
    tick(); tick();

    tag = "R9";
    for (int k = 0; k < 2000; k++) begin
      clr_in();
      if ($urandom_range(0, 15) == 0) begin
        wr_en = 1; wr_data = $urandom;
      end
      op_valid = ($urandom_range(0, 3) != 0);
      op_inv_cause = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0;
      op_ovf = $urandom_range(0, 1); op_unf = $urandom_range(0, 1);
      op_zdiv = $urandom_range(0, 1); op_inex = $urandom_range(0, 1);
      op_frac_rnd = $urandom_range(0, 1); op_frac_inx = $urandom_range(0, 1);
      op_rflags_we = $urandom_range(0, 1); op_cc_we = $urandom_range(0, 1);
      op_rflags = 5'($urandom); op_rc = $urandom_range(0, 1);
      tick();
    end
    clr_in();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule